// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a processor tuned for frequent procedure calls. Storage is split into a small bank of globals that every window sees and a circular pool of windowed registers. A window-number register picks which slice of the pool is visible. A call moves the window forward by one and gives the callee new local registers without saving anything. A return moves it back and makes the caller's registers visible again with their old contents.

Neighbouring windows share one group of eight registers. The registers a caller writes as outgoing arguments are the same physical storage that the callee reads as its incoming arguments, so no copy is needed in either direction. A resident-window counter tracks how many windows hold live data. When a call would use up the pool, the block raises an overflow exception and leaves the pointer where it is. When a return would go below the oldest resident window, it raises an underflow exception. An outside handler saves or restores one window to memory, reports this on an acknowledge input, and then retries the call or return.

The file has two combinational read ports and one write port. A write becomes visible to a read in the same cycle.

Top module: `rwf_window_file`

## Requirements
- R1: After reset, the current window is 0, one window is resident, and overflow and underflow are both low.
- R2: Logical registers 1 to 7 are globals and map to the same storage in every window. Logical register 0 always reads 0, and writes to it have no effect.
- R3: A call that does not trap advances the current window by one, modulo the window count. The new window's locals (logical 16 to 23) are separate from the caller's locals.
- R4: A return that does not trap moves the current window back by one. The locals and incoming registers of the window now current read back what was written before the call.
- R5: In window w, outgoing register 8+k is the same storage as incoming register 24+k in window w+1. Arguments pass from caller to callee, and results pass back, without copying.
- R6: A call made while the resident count equals the window count minus one does not move the window. It raises `overflow_o` for exactly one cycle, in the cycle after the call.
- R7: A return made while the resident count is 1 does not move the window. It raises `underflow_o` for exactly one cycle, in the cycle after the return.
- R8: `spill_ack_i` lowers the resident count by one, but not below 1. `fill_ack_i` raises it by one, but not above the window count minus one. Both are ignored in a cycle that has a call or return strobe, and a spill acknowledge takes priority over a fill acknowledge.
- R9: When the write port writes a physical register, a read of that register in the same cycle returns the written data.
- R10: Call and return never arrive in the same cycle. A write in the same cycle as a call or return goes to the window that was current before the pointer moved.
- R11: The window pointer wraps from the last window to window 0. After the wrap, the outgoing registers of the last window are the incoming registers of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| rs1_addr_i | input | 5 | Logical register number for read port 1 |
| rd1_data_o | output | DW | Read port 1 data (combinational) |
| rs2_addr_i | input | 5 | Logical register number for read port 2 |
| rd2_data_o | output | DW | Read port 2 data (combinational) |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Logical register number to write |
| wd_i | input | DW | Write data |
| call_i | input | 1 | Call strobe: advance the window |
| ret_i | input | 1 | Return strobe: move the window back |
| spill_ack_i | input | 1 | Handler has saved the oldest resident window |
| fill_ack_i | input | 1 | Handler has restored one window below the oldest |
| overflow_o | output | 1 | Pulse: a call found no free window |
| underflow_o | output | 1 | Pulse: a return found no resident caller window |
| cur_win_o | output | log2(NWIN) | Current window number |

## Verification
The bench builds the file with four windows and 16-bit data. With four windows, overflow is reached after two calls, and the pointer wraps from window 3 to window 0 after two spill acknowledges. Overflow, spill, wrap, return, underflow and fill then all fit in one short directed sequence. In that sequence, arguments and results cross the shared groups, the wrap overwrites only the incoming group of window 0, and the locals of every window are read back after the returns.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // Register group selected by the top two bits of a logical register number.
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } rwf_grp_e;

endpackage

// File: rtl/rwf_window_ctrl.sv
// Window pointer and resident-window counter with trap detection.
module rwf_window_ctrl #(
  parameter int NWIN = 8,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CW = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_ack_i,
  input  logic          fill_ack_i,
  output logic [WW-1:0] cwp_o,
  output logic          overflow_o,
  output logic          underflow_o
);

  localparam logic [CW-1:0] CNT_MAX = CW'(NWIN - 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(1);
  localparam logic [WW-1:0] WIN_LAST = WW'(NWIN - 1);

  logic [WW-1:0] cwp_q, cwp_d, cwp_inc, cwp_dec;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          win_en, cnt_en;

  assign cwp_inc = (cwp_q == WIN_LAST) ? '0 : cwp_q + WW'(1);
  assign cwp_dec = (cwp_q == '0) ? WIN_LAST : cwp_q - WW'(1);

  // Next-state logic
  always_comb begin
    cwp_d  = cwp_q;
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    win_en = 1'b0;
    cnt_en = 1'b0;
    if (call_i) begin
      if (cnt_q == CNT_MAX) begin
        ovf_d = 1'b1;
      end else begin
        cwp_d  = cwp_inc;
        cnt_d  = cnt_q + CW'(1);
        win_en = 1'b1;
        cnt_en = 1'b1;
      end
    end else if (ret_i) begin
      if (cnt_q == CNT_MIN) begin
        unf_d = 1'b1;
      end else begin
        cwp_d  = cwp_dec;
        cnt_d  = cnt_q - CW'(1);
        win_en = 1'b1;
        cnt_en = 1'b1;
      end
    end else if (spill_ack_i) begin
      if (cnt_q > CNT_MIN) begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
    end else if (fill_ack_i) begin
      if (cnt_q < CNT_MAX) begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      cnt_q <= CNT_MIN;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (win_en) cwp_q <= cwp_d;
      if (cnt_en) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o       = cwp_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // Resident count stays within its legal range (R6, R7, R8)
  assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CNT_MIN) && (cnt_q <= CNT_MAX));

  // Untrapped call advances the pointer by one (R3)
  assert_call_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && cnt_q != CNT_MAX)
      |=> (cwp_q == (($past(cwp_q) == WIN_LAST) ? '0 : $past(cwp_q) + WW'(1))));

  // Untrapped return moves the pointer back by one (R4)
  assert_ret_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && cnt_q != CNT_MIN)
      |=> (cwp_q == (($past(cwp_q) == '0) ? WIN_LAST : $past(cwp_q) - WW'(1))));

  // Trapped call raises overflow and freezes the pointer (R6)
  assert_no_overflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && cnt_q == CNT_MAX) |=> (overflow_o && $stable(cwp_q)));

  // Trapped return raises underflow and freezes the pointer (R7)
  assert_no_underflow_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && cnt_q == CNT_MIN) |=> (underflow_o && $stable(cwp_q)));

  // Call and return are exclusive (R10)
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i && ret_i));

endmodule

// File: rtl/rwf_addr_map.sv
// Maps a logical register number to a physical index through the window pointer.
module rwf_addr_map
  import rwf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  localparam int WW   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int OW   = $clog2(NREG),
  localparam int LW   = OW + 2,
  localparam int WTOT = NWIN * 2 * NREG,
  localparam int PW   = $clog2(NREG + WTOT)
) (
  input  logic [WW-1:0] cwp_i,
  input  logic [LW-1:0] laddr_i,
  output logic [PW-1:0] paddr_o
);

  localparam logic [WW-1:0] WIN_LAST = WW'(NWIN - 1);
  localparam logic [PW-1:0] STRIDE   = PW'(2 * NREG);
  localparam logic [PW-1:0] GBASE    = PW'(NREG);

  rwf_grp_e      grp;
  logic [OW-1:0] off;
  logic [WW-1:0] cwp_nx;
  logic [PW-1:0] base_cur, base_nx;

  assign grp      = rwf_grp_e'(laddr_i[LW-1:OW]);
  assign off      = laddr_i[OW-1:0];
  assign cwp_nx   = (cwp_i == WIN_LAST) ? '0 : cwp_i + WW'(1);
  assign base_cur = GBASE + PW'(cwp_i) * STRIDE;
  assign base_nx  = GBASE + PW'(cwp_nx) * STRIDE;

  always_comb begin
    unique case (grp)
      GRP_GLOBAL: paddr_o = PW'(off);
      GRP_OUT:    paddr_o = base_nx + PW'(off);
      GRP_LOCAL:  paddr_o = base_cur + PW'(NREG) + PW'(off);
      GRP_IN:     paddr_o = base_cur + PW'(off);
      default:    paddr_o = '0;
    endcase
  end

endmodule

// File: rtl/rwf_storage.sv
// Flat physical register array, NRD combinational read ports, write-first bypass.
module rwf_storage #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int NRD   = 2,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [PW-1:0]           wpa_i,
  input  logic [DW-1:0]           wd_i,
  input  logic [NRD-1:0][PW-1:0]  rpa_i,
  output logic [NRD-1:0][DW-1:0]  rd_o
);

  logic [DW-1:0]    mem [NPHYS];
  logic [NPHYS-1:0] wen;

  // Per-entry clock enables; entry 0 is the hard-wired zero and never written.
  always_comb begin
    wen = '0;
    for (int i = 1; i < NPHYS; i++) begin
      wen[i] = we_i && (wpa_i == PW'(i));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i < NPHYS; i++) begin
      if (wen[i]) mem[i] <= wd_i;
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
        if (rpa_i[p] == '0)
          rd_o[p] = '0;
        else if (we_i && (wpa_i == rpa_i[p]))
          rd_o[p] = wd_i;
        else
          rd_o[p] = mem[rpa_i[p]];
      end
    end
  endgenerate

endmodule

// File: rtl/rwf_window_file.sv
// Overlapping register window file: top level.
module rwf_window_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int NREG  = 8,
  localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int LW    = $clog2(NREG) + 2,
  localparam int WTOT  = NWIN * 2 * NREG,
  localparam int NPHYS = NREG + WTOT,
  localparam int PW    = $clog2(NPHYS),
  localparam int NPORT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rs1_addr_i,
  output logic [DW-1:0] rd1_data_o,
  input  logic [LW-1:0] rs2_addr_i,
  output logic [DW-1:0] rd2_data_o,
  input  logic          we_i,
  input  logic [LW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_ack_i,
  input  logic          fill_ack_i,
  output logic          overflow_o,
  output logic          underflow_o,
  output logic [WW-1:0] cur_win_o
);

  logic [WW-1:0]             cwp;
  logic [NPORT-1:0][LW-1:0]  laddr;
  logic [NPORT-1:0][PW-1:0]  paddr;
  logic [1:0][DW-1:0]        rdata;

  rwf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .spill_ack_i(spill_ack_i),
    .fill_ack_i (fill_ack_i),
    .cwp_o      (cwp),
    .overflow_o (overflow_o),
    .underflow_o(underflow_o)
  );

  // Port 0, 1: reads; port 2: write. All use the pointer before any move.
  assign laddr = {wa_i, rs2_addr_i, rs1_addr_i};

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_map
      rwf_addr_map #(.NWIN(NWIN), .NREG(NREG)) u_map (
        .cwp_i  (cwp),
        .laddr_i(laddr[p]),
        .paddr_o(paddr[p])
      );
    end
  endgenerate

  rwf_storage #(.DW(DW), .NPHYS(NPHYS), .NRD(2)) u_store (
    .clk  (clk),
    .we_i (we_i),
    .wpa_i(paddr[2]),
    .wd_i (wd_i),
    .rpa_i({paddr[1], paddr[0]}),
    .rd_o (rdata)
  );

  assign rd1_data_o = rdata[0];
  assign rd2_data_o = rdata[1];
  assign cur_win_o  = cwp;

  // Logical register 0 reads zero on both ports (R2)
  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rs1_addr_i == '0) |-> (rd1_data_o == '0)) and
    ((rs2_addr_i == '0) |-> (rd2_data_o == '0)));

endmodule

// File: tb/rwf_window_file_tb.sv
module rwf_window_file_tb;

  localparam int NWIN = 4;
  localparam int DW   = 16;

  typedef struct {
    int          kind;   // 0 rd1, 1 rd2, 2 overflow, 3 underflow, 4 window
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic          clk, rst_n;
  logic [4:0]    rs1, rs2, wa;
  logic [DW-1:0] rd1, rd2, wd;
  logic          we, call, ret, spill, fill;
  logic          ovf, unf;
  logic [1:0]    win;

  sb_item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rwf_window_file #(.NWIN(NWIN), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rs1_addr_i(rs1), .rd1_data_o(rd1),
    .rs2_addr_i(rs2), .rd2_data_o(rd2),
    .we_i(we), .wa_i(wa), .wd_i(wd),
    .call_i(call), .ret_i(ret),
    .spill_ack_i(spill), .fill_ack_i(fill),
    .overflow_o(ovf), .underflow_o(unf), .cur_win_o(win)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: pops every expectation pushed for this cycle and compares.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = 32'(rd1);
        1: act = 32'(rd2);
        2: act = 32'(ovf);
        3: act = 32'(unf);
        default: act = 32'(win);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] v, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    we = 0; call = 0; ret = 0; spill = 0; fill = 0;
  endtask

  task automatic state_chk(input int w, input bit o, input bit u, input string tag);
    expect_item(4, 32'(w), tag);
    expect_item(2, 32'(o), tag);
    expect_item(3, 32'(u), tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    we = 1; wa = a; wd = d;
    step();
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [DW-1:0] e, input string tag);
    rs1 = a;
    expect_item(0, 32'(e), tag);
    step();
  endtask

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rs1 = 0; rs2 = 0; wa = 0; wd = 0;
    we = 0; call = 0; ret = 0; spill = 0; fill = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    state_chk(0, 0, 0, "R1 reset state");
    rs1 = 0; expect_item(0, 0, "R1 reg0 after reset");
    step();

    // R2: globals and hard-wired zero
    wr(5, 16'h00A5);
    wr(0, 16'hFFFF);
    rs1 = 0; expect_item(0, 0, "R2 reg0 ignores write");
    rs2 = 5; expect_item(1, 32'h00A5, "R2 global readback");
    step();

    // Window 0 contents
    wr(16, 16'h1000);
    wr(24, 16'h1100);
    wr(8,  16'h1200);

    // R9: same-cycle write and read
    we = 1; wa = 17; wd = 16'h1717; rs1 = 17;
    expect_item(0, 32'h1717, "R9 write-first bypass");
    step();
    rd_chk(17, 16'h1717, "R9 value stored");

    // R3/R10: call with a write to outgoing 9 in the same cycle
    call = 1; we = 1; wa = 9; wd = 16'h1309;
    step();
    state_chk(1, 0, 0, "R3 call to window 1");
    rs1 = 24; expect_item(0, 32'h1200, "R5 argument out8->in24");
    rs2 = 25; expect_item(1, 32'h1309, "R10 write used old window");
    step();
    rd_chk(5, 16'h00A5, "R2 global in window 1");

    wr(16, 16'h2000);
    wr(26, 16'h2626);
    rd_chk(16, 16'h2000, "R3 fresh local in window 1");

    call = 1; step();
    state_chk(2, 0, 0, "R3 call to window 2");
    step();
    wr(16, 16'h3000);

    // R6: overflow at count NWIN-1
    call = 1; step();
    state_chk(2, 1, 0, "R6 overflow raised, window held");
    step();
    state_chk(2, 0, 0, "R6 overflow one cycle only");
    step();
    rd_chk(16, 16'h3000, "R6 window 2 data intact");

    // R8: spill frees a window, call proceeds
    spill = 1; step();
    call = 1; step();
    state_chk(3, 0, 0, "R8 call after spill");
    step();
    wr(16, 16'h4000);
    wr(8,  16'h4808);
    rd_chk(5, 16'h00A5, "R2 global in window 3");

    // R11: wrap to window 0
    spill = 1; step();
    call = 1; step();
    state_chk(0, 0, 0, "R11 wrap to window 0");
    rs1 = 24; expect_item(0, 32'h4808, "R11 last out is window 0 in");
    step();

    // R4: returns restore previous windows
    ret = 1; step();
    state_chk(3, 0, 0, "R4 return to window 3");
    rs1 = 16; expect_item(0, 32'h4000, "R4 window 3 local");
    step();
    ret = 1; step();
    state_chk(2, 0, 0, "R4 return to window 2");
    rs1 = 16; expect_item(0, 32'h3000, "R4 window 2 local");
    step();

    // R8: spill at count 1 is ignored; R7: underflow
    spill = 1; step();
    ret = 1; step();
    state_chk(2, 0, 1, "R7 underflow raised, window held");
    step();
    state_chk(2, 0, 0, "R7 underflow one cycle only");
    step();

    // R8: fill lets return proceed
    fill = 1; step();
    ret = 1; step();
    state_chk(1, 0, 0, "R8 return after fill");
    rs1 = 16; expect_item(0, 32'h2000, "R4 window 1 local");
    rs2 = 26; expect_item(1, 32'h2626, "R4 window 1 incoming");
    step();

    fill = 1; step();
    ret = 1; step();
    state_chk(0, 0, 0, "R8 return to window 0");
    rs1 = 10; expect_item(0, 32'h2626, "R5 result in26->out10");
    rs2 = 17; expect_item(1, 32'h1717, "R4 window 0 local");
    step();
    step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule